// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

The block is a register-mapped timer with a set of independent channels. Each channel holds a 64-bit interval value and a 64-bit down-counter. Each of those values is reached as two 32-bit words. A channel counts on its own prescaled tick, derived from a shared source-tick enable. It runs either periodically, reloading itself on every underflow, or once, stopping after its first underflow.

Underflows are collected in a shared status register that software clears by writing ones. A separate enable register selects which pending flags drive the single interrupt line. Software starts a channel by setting the enable and reload bits together. Clearing the enable bit takes effect only after a short drain of source ticks, so a counter that is being stopped is still seen moving for a fixed number of ticks.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero, all channels are idle and `irq` is low.
- R2: Register map. Interrupt enable is at 0x00 (bit n for channel n) and pending status is at 0x04. Channel n has its control word at 0x20*n+0x10, interval low/high at +0x14/+0x18 and count low/high at +0x1C/+0x20, all relative to 0x20*n. Control bit 0 is run enable, bit 1 is reload, bits 6:4 are the prescaler code and bit 7 selects one-shot (1) or periodic (0). Other addresses and bits read zero.
- R3: When the reload bit is set, on the next clock the count takes the full 64-bit interval and the reload bit reads zero again. The load happens whether or not the channel is enabled, and it takes priority over counting.
- R4: While running, the 64-bit count falls by one on each channel tick, borrowing from the high word into the low word.
- R5: In periodic mode, a channel tick that finds the count at zero is an underflow and reloads the interval, so underflows repeat every (interval+1) channel ticks.
- R6: In one-shot mode an underflow clears the run-enable bit. The count then stays at zero.
- R7: Prescaler code k gives a channel tick once every 2^k source ticks (k = 0..7).
- R8: Writing the control word with run enable cleared makes the enable bit read zero at once. The counter keeps counting for exactly STOP_SYNC further source ticks (default 2) and then holds.
- R9: An underflow sets the channel's status bit whatever the interrupt enable says. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R11: A write to one interval word changes only those 32 bits. The count words are read-only, and writes to them are ignored.
- R12: Channels are independent: one channel's writes and underflows change no other channel's state or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Source-clock tick enable feeding the prescalers and stop drain |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each bus write lasts one cycle and addresses a single register of the map. They also assume that `src_tick` is a clean enable sampled on `clk`. When the bench measures underflow periods it clears the status bit in the cycle after it sees `irq` rise, so it keeps the programmed period at four cycles or longer. This lets every underflow appear as a separate rise. The bench holds `src_tick` high, which makes prescaler and drain counts exact in clock cycles. It reprograms a channel only after stopping it and waiting out the drain.

// File: rtl/mct_pkg.sv
package mct_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned PSC_W  = 3;
  localparam int unsigned DIV_W  = (1 << PSC_W) - 1;

  localparam int IEN_OFF   = 'h00;
  localparam int STS_OFF   = 'h04;
  localparam int CH_STRIDE = 'h20;
  localparam int SUB_CTRL  = 'h10;
  localparam int SUB_IVLO  = 'h14;
  localparam int SUB_IVHI  = 'h18;
  localparam int SUB_CNLO  = 'h1C;
  localparam int SUB_CNHI  = 'h20;

  typedef struct packed {
    logic             oneshot;
    logic [PSC_W-1:0] psc;
    logic [1:0]       rsvd;
    logic             reload;
    logic             en;
  } ctrl_t;

  function automatic int reg_off(input int ch, input int sub);
    return CH_STRIDE * ch + sub;
  endfunction

  function automatic logic [DIV_W-1:0] psc_mask(input logic [PSC_W-1:0] k);
    logic [DIV_W:0] one;
    one = {{DIV_W{1'b0}}, 1'b1} << k;
    return DIV_W'(one - 1'b1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cnt,
                                                input logic [CNT_W-1:0] ivl,
                                                input logic oneshot);
    if (cnt != '0) return cnt - 1'b1;
    return oneshot ? '0 : ivl;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
    return {{(WORD_W-8){1'b0}}, c.oneshot, c.psc, 2'b00, c.reload, c.en};
  endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler
  import mct_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_tick,
  input  logic [NCH*PSC_W-1:0] psc_sel,
  output logic [NCH-1:0]       ch_tick
);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (src_tick) div_q <= div_q + 1'b1;
  end

  // R7
  div_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_tick |=> div_q == $past(div_q) + 1'b1);

  for (genvar i = 0; i < NCH; i++) begin : g_tick
    logic [DIV_W-1:0] msk;
    assign msk = psc_mask(psc_sel[i*PSC_W +: PSC_W]);
    assign ch_tick[i] = src_tick && ((div_q & msk) == msk);

    // R7
    tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> src_tick);
  end

endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int STOP_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              ch_tick,
  input  logic              wr_ctrl,
  input  logic              wr_ivl_lo,
  input  logic              wr_ivl_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  ivl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              uflow_o
);

  localparam int SYNC_W = (STOP_SYNC < 1) ? 1 : $clog2(STOP_SYNC + 1);

  ctrl_t              ctrl_r;
  logic               active;
  logic [SYNC_W-1:0]  drain;
  logic [CNT_W-1:0]   ivl, cnt;
  logic               counting, uflow, os_done;

  assign counting = active && ch_tick && !ctrl_r.reload;
  assign uflow    = counting && (cnt == '0);
  assign os_done  = uflow && ctrl_r.oneshot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      active <= 1'b0;
      drain  <= '0;
      ivl    <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ivl_lo) ivl[WORD_W-1:0]     <= wdata;
      if (wr_ivl_hi) ivl[CNT_W-1:WORD_W] <= wdata;

      if (ctrl_r.reload) begin
        cnt           <= ivl;
        ctrl_r.reload <= 1'b0;
      end else if (counting) begin
        cnt <= cnt_step(cnt, ivl, ctrl_r.oneshot);
      end

      if (os_done) begin
        active    <= 1'b0;
        ctrl_r.en <= 1'b0;
        drain     <= '0;
      end else if (drain != '0 && src_tick) begin
        drain <= drain - 1'b1;
        if (drain == SYNC_W'(1)) active <= 1'b0;
      end

      if (wr_ctrl) begin
        ctrl_r <= '{oneshot: wdata[7], psc: wdata[6:4], rsvd: 2'b00,
                    reload: wdata[1], en: wdata[0]};
        if (wdata[0]) begin
          active <= 1'b1;
          drain  <= '0;
        end else if (active && ctrl_r.en) begin
          if (STOP_SYNC == 0) active <= 1'b0;
          else                drain  <= SYNC_W'(STOP_SYNC);
        end
      end
    end
  end

  assign ctrl_o  = ctrl_word(ctrl_r);
  assign psc_o   = ctrl_r.psc;
  assign ivl_o   = ivl;
  assign cnt_o   = cnt;
  assign uflow_o = uflow;

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_r.reload && !wr_ctrl) |=> (cnt == $past(ivl)) && !ctrl_r.reload);

  // R4
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ch_tick && !ctrl_r.reload && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R5
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !ctrl_r.oneshot) |=> cnt == $past(ivl));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_done && !wr_ctrl) |=> !active && !ctrl_r.en && cnt == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ctrl_r.reload) |=> $stable(cnt));

  // R8
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain == SYNC_W'(1) && src_tick && !wr_ctrl) |=> !active);

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int ADDR_W    = 8,
  parameter int STOP_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic                 wr;
  int                   addr_i;
  logic [NCH-1:0]       ien_q, sts_q, sts_clr, uflow, ch_tick;
  logic [NCH*PSC_W-1:0] psc_bus;
  logic [WORD_W-1:0]    ctrl_w [NCH];
  logic [CNT_W-1:0]     ivl_w  [NCH];
  logic [CNT_W-1:0]     cnt_w  [NCH];
  logic [WORD_W-1:0]    rdata_c;

  assign wr     = bus_sel && bus_we;
  assign addr_i = int'(bus_addr);

  mct_prescaler #(.NCH(NCH)) psc_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .psc_sel(psc_bus), .ch_tick(ch_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_ctrl, wr_lo, wr_hi;
    assign wr_ctrl = wr && addr_i == reg_off(i, SUB_CTRL);
    assign wr_lo   = wr && addr_i == reg_off(i, SUB_IVLO);
    assign wr_hi   = wr && addr_i == reg_off(i, SUB_IVHI);

    mct_channel #(.STOP_SYNC(STOP_SYNC)) ch_i (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ch_tick(ch_tick[i]),
      .wr_ctrl(wr_ctrl), .wr_ivl_lo(wr_lo), .wr_ivl_hi(wr_hi),
      .wdata(bus_wdata), .ctrl_o(ctrl_w[i]),
      .psc_o(psc_bus[i*PSC_W +: PSC_W]), .ivl_o(ivl_w[i]),
      .cnt_o(cnt_w[i]), .uflow_o(uflow[i])
    );

    // R9
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[i] |=> sts_q[i]);

    // R9
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_i == STS_OFF && bus_wdata[i] && !uflow[i]) |=> !sts_q[i]);
  end

  assign sts_clr = (wr && addr_i == STS_OFF) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr && addr_i == IEN_OFF) ien_q <= bus_wdata[NCH-1:0];
      sts_q <= (sts_q & ~sts_clr) | uflow;
    end
  end

  always_comb begin
    rdata_c = '0;
    if (addr_i == IEN_OFF) rdata_c = WORD_W'(ien_q);
    if (addr_i == STS_OFF) rdata_c = WORD_W'(sts_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == reg_off(i, SUB_CTRL)) rdata_c = ctrl_w[i];
      if (addr_i == reg_off(i, SUB_IVLO)) rdata_c = ivl_w[i][WORD_W-1:0];
      if (addr_i == reg_off(i, SUB_IVHI)) rdata_c = ivl_w[i][CNT_W-1:WORD_W];
      if (addr_i == reg_off(i, SUB_CNLO)) rdata_c = cnt_w[i][WORD_W-1:0];
      if (addr_i == reg_off(i, SUB_CNHI)) rdata_c = cnt_w[i][CNT_W-1:WORD_W];
    end
  end

  assign bus_rdata = bus_sel ? rdata_c : '0;
  assign irq       = |(sts_q & ien_q);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));

endmodule

// File: tb/mct_timer_tb.sv
module mct_timer_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mct_timer dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int a_ctl(input int ch);  return 32*ch + 16; endfunction
  function automatic int a_ilo(input int ch);  return 32*ch + 20; endfunction
  function automatic int a_ihi(input int ch);  return 32*ch + 24; endfunction
  function automatic int a_clo(input int ch);  return 32*ch + 28; endfunction
  function automatic int a_chi(input int ch);  return 32*ch + 32; endfunction
  function automatic int exp_period(input int n, input int k); return (n + 1) << k; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic measure(input int n, input int k, output int gap);
    int ev, t2, t3, cyc;
    ev = 0; t2 = 0; t3 = 0; cyc = 0;
    wr(a_ctl(0), 32'h0);
    repeat (4) @(posedge clk);
    wr(a_ilo(0), 32'(n));
    wr(a_ihi(0), 32'h0);
    wr(4, 32'h3);
    wr(0, 32'h1);
    wr(a_ctl(0), 32'(k << 4) | 32'h3);
    while (ev < 3 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (irq) begin
        ev++;
        if (ev == 2) t2 = cyc;
        if (ev == 3) t3 = cyc;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'd4; bus_wdata = 32'h1;
      end else begin
        bus_sel = 1'b0; bus_we = 1'b0;
      end
    end
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
    gap = t3 - t2;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c;
    int gap;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(0, d);          chk("R1 ien", d, 0);
    rd(4, d);          chk("R1 sts", d, 0);
    rd(a_ctl(0), d);   chk("R1 ctrl0", d, 0);
    rd(a_ihi(1), d);   chk("R1 ivl hi1", d, 0);
    rd(a_clo(1), d);   chk("R1 cnt lo1", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // R11 interval words independent, count read-only
    wr(a_ihi(0), 32'hA5A5_0001);
    wr(a_ilo(0), 32'h1234_5678);
    rd(a_ihi(0), d);   chk("R11 ivl hi kept", d, 32'hA5A5_0001);
    rd(a_ilo(0), d);   chk("R11 ivl lo", d, 32'h1234_5678);
    wr(a_clo(0), 32'h0000_FFFF);
    rd(a_clo(0), d);   chk("R11 cnt write ignored", d, 0);

    // R3 reload without enable; R2 field positions
    wr(a_ctl(0), 32'h2);
    rd(a_ctl(0), d);   chk("R2 reload bit", d, 32'h2);
    rd(a_clo(0), d);   chk("R3 load lo", d, 32'h1234_5678);
    rd(a_chi(0), d);   chk("R3 load hi", d, 32'hA5A5_0001);
    rd(a_ctl(0), d);   chk("R3 reload self-clear", d, 0);

    // R4 64-bit borrow while counting
    wr(a_ihi(0), 32'h1);
    wr(a_ilo(0), 32'h2);
    wr(a_ctl(0), 32'h3);
    repeat (3) @(posedge clk);
    rd(a_chi(0), d);   chk("R4 hi before borrow", d, 32'h1);
    rd(a_clo(0), d);   chk("R4 lo after borrow", d, 32'hFFFF_FFFF);
    rd(a_chi(0), d);   chk("R4 hi after borrow", d, 32'h0);

    // R8 stop drain
    wr(a_ctl(0), 32'h0);
    rd(a_clo(0), c);
    repeat (5) @(posedge clk);
    rd(a_clo(0), d);   chk("R8 two drain ticks", d, c - 32'd2);
    rd(a_ctl(0), d);   chk("R8 enable reads zero", d, 0);
    repeat (3) @(posedge clk);
    rd(a_clo(0), d);   chk("R8 held", d, c - 32'd2);

    // R6 one-shot, R9 status without enable, R10 gating
    wr(4, 32'h3);
    wr(a_ihi(0), 32'h0);
    wr(a_ilo(0), 32'h4);
    wr(a_ctl(0), 32'h83);
    repeat (5) @(posedge clk);
    rd(4, d);          chk("R6 no flag before underflow", d, 0);
    rd(4, d);          chk("R9 flag set with ien off", d, 32'h1);
    chk("R10 irq masked", 32'(irq), 0);
    rd(a_ctl(0), d);   chk("R6 enable cleared", d, 32'h80);
    repeat (4) @(posedge clk);
    rd(a_clo(0), d);   chk("R6 count held zero", d, 0);
    wr(0, 32'h1);
    @(negedge clk);    chk("R10 irq raised", 32'(irq), 1);
    wr(4, 32'h0);
    rd(4, d);          chk("R9 write zero keeps", d, 32'h1);
    wr(4, 32'h1);
    rd(4, d);          chk("R9 write one clears", d, 0);
    chk("R10 irq dropped", 32'(irq), 0);

    // R12 channel independence
    wr(a_ilo(1), 32'h2);
    wr(a_ctl(1), 32'h83);
    repeat (10) @(posedge clk);
    rd(4, d);          chk("R12 only ch1 flag", d, 32'h2);
    rd(a_ctl(0), d);   chk("R12 ch0 ctrl untouched", d, 32'h80);
    rd(a_clo(0), d);   chk("R12 ch0 count untouched", d, 0);
    rd(a_ctl(1), d);   chk("R12 ch1 stopped", d, 32'h80);

    // R5 R7 directed corner: slowest prescaler
    measure(1, 7, gap);
    chk("R7 psc7 period", 32'(gap), 32'(exp_period(1, 7)));
    rd(a_ctl(0), d);   chk("R2 psc field readback", d, 32'h71);

    // R5 R7 random periods
    for (int t = 0; t < 8; t++) begin
      int n, k;
      n = 3 + int'($urandom % 10);
      k = int'($urandom % 4);
      measure(n, k, gap);
      chk($sformatf("R5 R7 period n=%0d k=%0d", n, k), 32'(gap), 32'(exp_period(n, k)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule